// File: doc/BRIEF.md
# Four-Register LED Slave with Offset Readback

This block is a register slave on a simple synchronous processor bus. It decodes four word-aligned registers, and each register owns one LED output. A write that passes the bus qualification sets that register's LED from bit 0 of the write data. The same write stores the low byte of the write data in a single shared capture register. A read returns the stored byte plus a small constant equal to the register index. The result is zero-extended to the full bus width.

Both acknowledges and the read data are registered, so software sees the response one cycle after the strobe. Reads and writes may arrive in the same cycle and both complete. In that case the read returns the byte that was stored before the write.

Top module: `ledreg_periph`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all four LEDs are off, `rd_ack`, `wr_ack` and `rd_data` are zero, and the capture register holds 0x00, so a first read of register n returns n.
- R2: A write takes effect only in a cycle where `cs` and `wr_stb` are both high. Any other cycle leaves the LEDs and the capture register unchanged.
- R3: A qualified write to register n sets `led[n]` to `wr_data[0]` on the next cycle and leaves the other three LEDs unchanged. `led[n]` is bit n of `led`.
- R4: A qualified write stores `wr_data[7:0]` into the capture register. Bits 31..8 of the write data are ignored.
- R5: A qualified read of register n returns the capture value plus n, computed at 32 bits and zero-extended. For example, 0xFF read at register 3 gives 0x00000102.
- R6: The register index is `addr[3:2]`. Registers therefore sit on consecutive 32-bit words, and all other address bits are ignored.
- R7: `rd_ack` is high for exactly the cycle after a cycle in which `cs` and `rd_stb` are both high, and `rd_data` holds the result in that cycle. `rd_data` is zero in every cycle in which `rd_ack` is low, including every cycle after one with `cs` low.
- R8: `wr_ack` is high for exactly the cycle after a qualified write.
- R9: When a qualified read and a qualified write fall in the same cycle, both complete. The read returns the capture value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| addr | input | 32 | Byte address; register index taken from bits 3:2 |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, zero when no read completes |
| rd_ack | output | 1 | One-cycle read acknowledge |
| wr_ack | output | 1 | One-cycle write acknowledge |
| led | output | 4 | One LED per register |

## Verification
The bench targets several corner cases:
- A stored 0xFF read at register 3. A design that adds at 8 bits returns 0x02 here instead of 0x102.
- Writes carrying set bits above bit 7 and addresses with bits set outside 3:2. A decoder that uses the wrong bits lands on the wrong LED, and a capture register that is too wide leaks junk into the reads.
- Strobes raised with `cs` low, and `cs` raised without a strobe. A loose qualification shows up as a changed LED, a changed capture byte or a spurious acknowledge.
- A read and a write in the same cycle. A design that forwards the new byte returns the post-write value instead of the old one.

// File: rtl/ledreg_pkg.sv
package ledreg_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;

  function automatic strobe_t qualify(input logic cs, input logic rd, input logic wr);
    strobe_t s;
    s.rd = cs & rd;
    s.wr = cs & wr;
    return s;
  endfunction
endpackage

// File: rtl/ledreg_decode.sv
module ledreg_decode #(
  parameter int ADDR_W  = 32,
  parameter int NUM_REG = 4,
  parameter int SEL_LSB = 2,
  localparam int IDX_W  = $clog2(NUM_REG)
) (
  input  logic              cs,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_en,
  output logic              wr_en,
  output logic [NUM_REG-1:0] wr_hot
);
  import ledreg_pkg::*;
  strobe_t q;

  always_comb begin
    q      = qualify(cs, rd_stb, wr_stb);
    rd_en  = q.rd;
    wr_en  = q.wr;
    idx    = addr[SEL_LSB +: IDX_W];
    wr_hot = '0;
    wr_hot[idx] = q.wr;
  end
endmodule

// File: rtl/ledreg_led_bank.sv
module ledreg_led_bank #(
  parameter int NUM_REG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REG-1:0] wr_hot,
  input  logic               bit_in,
  output logic [NUM_REG-1:0] led
);
  for (genvar g = 0; g < NUM_REG; g++) begin : g_led
    always_ff @(posedge clk) begin
      if (rst)            led[g] <= 1'b0;
      else if (wr_hot[g]) led[g] <= bit_in;
    end
  end

  AST_ONE_LED_MOVES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(led ^ $past(led)) <= 1); // R3
  AST_LED_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_hot == '0) |=> $stable(led)); // R2
endmodule

// File: rtl/ledreg_readback.sv
module ledreg_readback #(
  parameter int DATA_W  = 32,
  parameter int CAP_W   = 8,
  parameter int NUM_REG = 4,
  localparam int IDX_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack
);
  logic [CAP_W-1:0]  cap_q;
  logic [DATA_W-1:0] sum;

  always_comb sum = DATA_W'(cap_q) + DATA_W'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else begin
      if (wr_en) cap_q <= wr_data[CAP_W-1:0];
      rd_ack  <= rd_en;
      rd_data <= rd_en ? sum : '0;
    end
  end

  AST_CAP_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cap_q)); // R4
  AST_RD_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> (rd_data == '0)); // R7
  AST_RD_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> (rd_data <= DATA_W'((1 << CAP_W) - 1 + NUM_REG - 1))); // R5
endmodule

// File: rtl/ledreg_periph.sv
module ledreg_periph #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int NUM_REG = 4,
  parameter int SEL_LSB = 2,
  parameter int CAP_W   = 8,
  localparam int IDX_W  = $clog2(NUM_REG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_ack,
  output logic               wr_ack,
  output logic [NUM_REG-1:0] led
);
  logic [IDX_W-1:0]   idx;
  logic               rd_en, wr_en;
  logic [NUM_REG-1:0] wr_hot;

  ledreg_decode #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .SEL_LSB(SEL_LSB)) u_dec (
    .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
    .idx(idx), .rd_en(rd_en), .wr_en(wr_en), .wr_hot(wr_hot)
  );

  ledreg_led_bank #(.NUM_REG(NUM_REG)) u_leds (
    .clk(clk), .rst(rst), .wr_hot(wr_hot), .bit_in(wr_data[0]), .led(led)
  );

  ledreg_readback #(.DATA_W(DATA_W), .CAP_W(CAP_W), .NUM_REG(NUM_REG)) u_rb (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .idx(idx),
    .wr_data(wr_data), .rd_data(rd_data), .rd_ack(rd_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_ack <= 1'b0;
    else     wr_ack <= wr_en;
  end

  AST_WR_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_stb) |=> wr_ack); // R8
  AST_WR_ACK_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr_stb) |=> !wr_ack); // R8
  AST_RD_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cs && rd_stb) |=> rd_ack); // R7
  AST_RD_ACK_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd_stb) |=> !rd_ack); // R7
  AST_NO_CS_NO_LED: assert property (@(posedge clk) disable iff (rst)
    !cs |=> $stable(led)); // R2
endmodule

// File: tb/ledreg_periph_tb.sv
`timescale 1ns/100ps
module ledreg_periph_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [31:0] addr = '0, wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_ack, wr_ack;
  logic [3:0]  led;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [3:0]  m_led = '0;
  int          m_cap = 0;
  logic [31:0] e_rd = '0;
  logic        e_rack = 1'b0, e_wack = 1'b0;

  always #2.5 clk = ~clk;

  ledreg_periph u_dut (
    .clk(clk), .rst(rst), .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_ack(rd_ack),
    .wr_ack(wr_ack), .led(led)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive, model at the edge, compare after it
  task automatic step(input logic r, input logic s, input logic rd, input logic wr,
                      input logic [31:0] a, input logic [31:0] d, input string tag);
    int n;
    rst = r; cs = s; rd_stb = rd; wr_stb = wr; addr = a; wr_data = d;
    @(posedge clk);
    n = (a / 4) % 4;
    if (r) begin
      m_led = '0; m_cap = 0; e_rd = '0; e_rack = 0; e_wack = 0;
    end else begin
      e_rack = s && rd;
      e_rd   = e_rack ? 32'(m_cap + n) : 32'd0;
      e_wack = s && wr;
      if (s && wr) begin
        m_led[n] = d[0];
        m_cap    = int'(d % 256);
      end
    end
    @(negedge clk);
    chk({tag, " led R3"}, 32'(led), 32'(m_led));
    chk({tag, " rd_data R5"}, rd_data, e_rd);
    chk({tag, " rd_ack R7"}, 32'(rd_ack), 32'(e_rack));
    chk({tag, " wr_ack R8"}, 32'(wr_ack), 32'(e_wack));
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    step(0, 1, 1, 0, a, 32'h0, tag);
  endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    step(0, 1, 0, 1, a, d, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 0, 0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 32'h4, 32'hFFFF_FFFF, "R1 reset");
    idle("R1 after reset");
    for (int i = 0; i < 4; i++) rd(32'(i * 4), "R1 first reads");
    wr(32'h0, 32'h1, "R3 led0 on");
    wr(32'h8, 32'hA5, "R3 led2 on");
    rd(32'hC, "R5 read A5+3");
    wr(32'h4, 32'hFF, "R3 led1 on");
    rd(32'hC, "R5 no wrap 0xFF+3");
    rd(32'h0, "R5 read FF+0");
    step(0, 0, 0, 1, 32'h0, 32'h0, "R2 wr_stb no cs");
    step(0, 1, 0, 0, 32'h4, 32'h0, "R2 cs no strobe");
    step(0, 0, 1, 0, 32'h8, 32'h0, "R7 rd_stb no cs");
    rd(32'h4, "R2 cap unchanged");
    wr(32'h10, 32'hDEAD_BE12, "R6 high addr bit to reg0");
    wr(32'hFFFF_FFF8, 32'h0000_0100, "R4 upper data ignored reg2");
    rd(32'hFFFF_FFF4, "R6 high bits read reg1");
    wr(32'h4, 32'h12, "R4 restore");
    step(0, 1, 1, 1, 32'hC, 32'h40, "R9 rd+wr same cycle");
    rd(32'h4, "R9 after write");
    rd(32'h8, "R7 back to back");
    rd(32'hC, "R7 back to back");
    wr(32'hC, 32'h0, "R3 led3 off");
    wr(32'h0, 32'h3, "R3 led0 on");
    idle("R7 idle zero");
    idle("R8 idle");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule